// File: doc/BRIEF.md
# Mode-Based Energy Accumulator

This block keeps a running estimate of the energy a neighbouring component has used. It models the component with three operating modes: powered off, idle and active. Every clock it adds a cost to a saturating total. In idle or active mode the cost is a per-mode base value plus weighted activity: memory reads and writes, add-class and multiply-class operations, and the number of bus bits that flipped since the previous cycle. In the powered-off mode it adds only a leakage constant.

Mode requests move the model between modes. Each move charges a one-time cost that depends on the destination mode. After the move the block stays busy for a latency, also chosen per destination. While it is busy it ignores new requests and does not charge per-cycle cost. The weights, base costs, leakage, move costs and move latencies sit in a small register file. That register file accepts writes only while reset is asserted, or while the model is powered off and not busy.

Top module: `energy_meter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode reads 0 (powered off), busy reads 0 and energy reads 0. Mode encoding: 0 = off, 1 = idle, 2 = active.
- R2: When not busy, the highest-priority asserted request wins. The order is off request first, then active, then idle. A winning request that names the current mode changes nothing, and the normal per-cycle cost is added.
- R3: On the edge that accepts a mode change, the new mode appears and the move cost of the destination mode is added to energy. No other cost is added on that edge.
- R4: After an accepted change, busy stays high for exactly the destination's latency in cycles (0 gives no busy cycles). While busy, mode requests are ignored and nothing is added to energy.
- R5: In idle or active mode, when not busy and no change is accepted, each cycle adds: the mode's base cost, plus the weight of each asserted strobe (read, write, add, multiply), plus the toggle weight times the toggle count.
- R6: In the off mode, when not busy and no change is accepted, each cycle adds only the leakage constant. Activity strobes and bus toggles have no effect.
- R7: The toggle count is the number of set bits in the XOR of bus_in with its value on the previous cycle. The previous value is sampled on every cycle, busy or not, and is 0 after reset.
- R8: Energy saturates at 2^EW-1 and holds there instead of wrapping.
- R9: While energy_clr is high, energy becomes 0 on the next edge. Clear takes priority over any increment.
- R10: A configuration write takes effect only while reset is asserted or while the mode is off and busy is low. At any other time it is ignored. Addresses:
  - 0..3: weights for read, write, add and multiply.
  - 4: toggle weight.
  - 5, 6: base costs for idle and active.
  - 7: leakage.
  - 8, 9, 10: move costs into off, idle and active.
  - 11, 12, 13: latencies into off, idle and active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_off | input | 1 | Request the powered-off mode |
| req_idle | input | 1 | Request the idle mode |
| req_active | input | 1 | Request the active mode |
| ev_rd | input | 1 | Memory read this cycle |
| ev_wr | input | 1 | Memory write this cycle |
| ev_add | input | 1 | Add-class operation this cycle |
| ev_mul | input | 1 | Multiply-class operation this cycle |
| bus_in | input | BW | Observed bus value |
| energy_clr | input | 1 | Synchronous clear of the total |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | DW | Configuration write data |
| mode | output | 2 | Current mode |
| busy | output | 1 | Mode move latency in progress |
| energy | output | EW | Saturating energy total |

## Verification
The bench builds the block with DW=8, BW=8 and EW=20 rather than the default 48-bit total. A narrow total lets a few hundred cycles of maximum-cost activity drive energy into saturation, so the hold-at-maximum behaviour and the clear that follows it can both be seen at the port. With 8-bit weights and an 8-bit bus, small hand-computed sums also check:
- every weighted term of the per-cycle cost;
- toggle counts from 1 to 8 bits;
- non-zero and zero move latencies.

// File: rtl/em_pkg.sv
// Shared types and configuration indices for the energy accumulator.
// Assumes the mode encoding below is visible at the top-level port.
package em_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_ACTIVE = 2'd2
    } mode_e;

    localparam int NCFG      = 14;
    localparam int A_W_RD    = 0;
    localparam int A_W_WR    = 1;
    localparam int A_W_ADD   = 2;
    localparam int A_W_MUL   = 3;
    localparam int A_W_TOG   = 4;
    localparam int A_B_IDLE  = 5;
    localparam int A_B_ACT   = 6;
    localparam int A_LEAK    = 7;
    localparam int A_TE_BASE = 8;   // plus mode code
    localparam int A_LAT_BASE = 11; // plus mode code
endpackage

// File: rtl/em_toggle_count.sv
// Counts bus bits that changed since the previous cycle.
// Assumes the previous value is sampled every cycle and resets to zero.
module em_toggle_count #(
    parameter int BW = 32,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bus_in,
    output logic [CW-1:0] tog_cnt
);
    logic [BW-1:0] prev_q;
    logic [BW-1:0] diff;

    // Remember last cycle's bus value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= bus_in;
    end

    // Population count of the changed bits.
    always_comb begin
        diff    = bus_in ^ prev_q;
        tog_cnt = '0;
        for (int i = 0; i < BW; i++) tog_cnt = tog_cnt + CW'(diff[i]);
    end
endmodule

// File: rtl/em_mode_fsm.sv
// Mode tracker: picks a request by priority, moves the mode and then holds
// busy for the destination's latency. Assumes latencies are stable while busy.
module em_mode_fsm
    import em_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_off,
    input  logic          req_idle,
    input  logic          req_active,
    input  logic [DW-1:0] lat_off,
    input  logic [DW-1:0] lat_idle,
    input  logic [DW-1:0] lat_active,
    output mode_e         mode,
    output logic          busy,
    output logic          take,
    output mode_e         tgt
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] lat_sel;
    logic          any_req;

    // Resolve the winning request and whether it is accepted.
    always_comb begin
        any_req = req_off | req_idle | req_active;
        if (req_off)         tgt = MODE_OFF;
        else if (req_active) tgt = MODE_ACTIVE;
        else                 tgt = MODE_IDLE;
        take = !busy && any_req && (tgt != mode);
        case (tgt)
            MODE_OFF:    lat_sel = lat_off;
            MODE_ACTIVE: lat_sel = lat_active;
            default:     lat_sel = lat_idle;
        endcase
    end

    assign busy = (cnt_q != '0);

    // Mode register and move-latency countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_OFF;
            cnt_q <= '0;
        end else if (take) begin
            mode  <= tgt;
            cnt_q <= lat_sel;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_busy_holds_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mode == $past(mode)));
    p_change_after_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> !$past(busy));
    p_take_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (mode == $past(tgt)));
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);
endmodule

// File: rtl/em_sat_accum.sv
// Saturating accumulator with synchronous clear.
// Assumes IW <= EW so an increment fits the total.
module em_sat_accum #(
    parameter int EW = 48,
    parameter int IW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [EW-1:0] acc
);
    logic [EW:0] sum;

    // Wide sum; its top bit flags overflow.
    always_comb sum = {1'b0, acc} + (EW + 1)'(inc);

    // Clear first, then clamp or add.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (sum[EW])  acc <= '1;
        else               acc <= sum[EW-1:0];
    end

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (acc >= $past(acc)));
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&acc) && !clr) |=> (&acc));
endmodule

// File: rtl/energy_meter.sv
// Energy accumulator top: configuration registers, per-cycle cost selection,
// mode tracker, toggle counter and saturating total.
// Assumes configuration registers carry no reset and are loaded during reset
// or while powered off and not busy.
module energy_meter
    import em_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 32,
    parameter int EW = 48,
    localparam int AW = 4,
    localparam int CW = $clog2(BW + 1),
    localparam int IW = DW + CW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_off,
    input  logic          req_idle,
    input  logic          req_active,
    input  logic          ev_rd,
    input  logic          ev_wr,
    input  logic          ev_add,
    input  logic          ev_mul,
    input  logic [BW-1:0] bus_in,
    input  logic          energy_clr,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [1:0]    mode,
    output logic          busy,
    output logic [EW-1:0] energy
);
    logic [DW-1:0] cfg_q [NCFG];
    logic          cfg_open;
    logic          take;
    mode_e         mode_q;
    mode_e         tgt;
    logic [CW-1:0] tog_cnt;
    logic [IW-1:0] inc;
    logic [IW-1:0] act_cost;
    logic [DW-1:0] base_sel;
    logic [DW-1:0] te_sel;

    assign cfg_open = !rst_n || (mode_q == MODE_OFF && !busy);

    // One register per configuration entry, written only when open.
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (cfg_we && cfg_open && cfg_addr == AW'(g)) cfg_q[g] <= cfg_wdata;
        end
    end

    em_mode_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_off(req_off), .req_idle(req_idle), .req_active(req_active),
        .lat_off(cfg_q[A_LAT_BASE]), .lat_idle(cfg_q[A_LAT_BASE + 1]),
        .lat_active(cfg_q[A_LAT_BASE + 2]),
        .mode(mode_q), .busy(busy), .take(take), .tgt(tgt)
    );

    em_toggle_count #(.BW(BW)) u_tog (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tog_cnt(tog_cnt)
    );

    // Select this cycle's energy increment.
    always_comb begin
        case (tgt)
            MODE_OFF:    te_sel = cfg_q[A_TE_BASE];
            MODE_ACTIVE: te_sel = cfg_q[A_TE_BASE + 2];
            default:     te_sel = cfg_q[A_TE_BASE + 1];
        endcase
        base_sel = (mode_q == MODE_ACTIVE) ? cfg_q[A_B_ACT] : cfg_q[A_B_IDLE];
        act_cost = IW'(base_sel)
                 + (ev_rd  ? IW'(cfg_q[A_W_RD])  : '0)
                 + (ev_wr  ? IW'(cfg_q[A_W_WR])  : '0)
                 + (ev_add ? IW'(cfg_q[A_W_ADD]) : '0)
                 + (ev_mul ? IW'(cfg_q[A_W_MUL]) : '0)
                 + IW'(cfg_q[A_W_TOG]) * IW'(tog_cnt);
        if (busy)                     inc = '0;
        else if (take)                inc = IW'(te_sel);
        else if (mode_q == MODE_OFF)  inc = IW'(cfg_q[A_LEAK]);
        else                          inc = act_cost;
    end

    em_sat_accum #(.EW(EW), .IW(IW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(energy_clr), .inc(inc), .acc(energy)
    );

    assign mode = mode_q;

    p_busy_no_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !energy_clr) |=> (energy == $past(energy)));
    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_OFF) |=> (cfg_q[A_B_ACT] == $past(cfg_q[A_B_ACT])));
endmodule

// File: tb/energy_meter_tb.sv
module energy_meter_tb;
    localparam int DW = 8;
    localparam int BW = 8;
    localparam int EW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_off = 0, req_idle = 0, req_active = 0;
    logic          ev_rd = 0, ev_wr = 0, ev_add = 0, ev_mul = 0;
    logic [BW-1:0] bus_in = '0;
    logic          energy_clr = 0;
    logic          cfg_we = 0;
    logic [3:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [1:0]    mode;
    logic          busy;
    logic [EW-1:0] energy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    energy_meter #(.DW(DW), .BW(BW), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_off(req_off), .req_idle(req_idle), .req_active(req_active),
        .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_add(ev_add), .ev_mul(ev_mul),
        .bus_in(bus_in), .energy_clr(energy_clr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mode(mode), .busy(busy), .energy(energy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input int a, input int d);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = DW'(d);
        tick();
        cfg_we = 0;
    endtask

    task automatic set_ev(input bit r, input bit w, input bit a, input bit m);
        ev_rd = r; ev_wr = w; ev_add = a; ev_mul = m;
    endtask

    // R1, R10: load configuration during reset, check the reset state.
    task automatic t_reset();
        rst_n = 0;
        tick();
        wr_cfg(0, 1);  wr_cfg(1, 2);  wr_cfg(2, 3);  wr_cfg(3, 5);
        wr_cfg(4, 7);  wr_cfg(5, 10); wr_cfg(6, 20); wr_cfg(7, 1);
        wr_cfg(8, 40); wr_cfg(9, 50); wr_cfg(10, 60);
        wr_cfg(11, 2); wr_cfg(12, 0); wr_cfg(13, 3);
        chk("R1 mode", mode, 0);
        chk("R1 busy", busy, 0);
        chk("R1 energy", energy, 0);
        rst_n = 1;
    endtask

    // R9 clear wins over leak; R6 off mode ignores strobes; R7 toggles.
    task automatic t_off_leak();
        energy_clr = 1;
        tick(); tick();
        chk("R9 clear held", energy, 0);
        energy_clr = 0;
        set_ev(1, 1, 1, 1);
        bus_in = 8'hFF;
        repeat (4) tick();
        chk("R6 leak only", energy, 4);
    endtask

    // R2 priority, R3 move cost, R4 latency and ignored requests.
    task automatic t_to_active();
        energy_clr = 1; tick(); energy_clr = 0;
        req_active = 1; req_idle = 1;
        tick();
        req_active = 0; req_idle = 0;
        chk("R2 active over idle", mode, 2);
        chk("R3 move cost", energy, 60);
        chk("R4 busy start", busy, 1);
        req_off = 1;
        tick(); tick();
        chk("R4 busy mid", busy, 1);
        tick();
        chk("R4 busy end", busy, 0);
        chk("R4 no charge while busy", energy, 60);
        chk("R4 request ignored", mode, 2);
        req_off = 0;
        set_ev(0, 0, 0, 0);
    endtask

    // R5 weighted sum, R7 toggle count.
    task automatic t_active_events();
        energy_clr = 1; tick(); energy_clr = 0;
        chk("R9 clear in active", energy, 0);
        set_ev(1, 0, 0, 1); bus_in = 8'hF0;
        tick();
        chk("R5 rd+mul+4 toggles", energy, 54);
        set_ev(0, 1, 1, 0);
        tick();
        chk("R5 wr+add", energy, 79);
        set_ev(0, 0, 0, 0); bus_in = 8'hF1;
        tick();
        chk("R7 one toggle", energy, 106);
    endtask

    // R10 write ignored outside off; R2 request for current mode.
    task automatic t_locked_and_same();
        wr_cfg(6, 100);
        chk("R10 write cycle", energy, 126);
        tick();
        chk("R10 base unchanged", energy, 146);
        req_active = 1;
        tick();
        req_active = 0;
        chk("R2 same mode cost", energy, 166);
        chk("R2 same mode busy", busy, 0);
    endtask

    // R2 off wins; R4 latency 2; R6 leak after.
    task automatic t_to_off();
        req_off = 1; req_idle = 1; req_active = 1;
        set_ev(1, 1, 1, 1);
        tick();
        req_off = 0; req_idle = 0; req_active = 0;
        chk("R2 off wins", mode, 0);
        chk("R3 off move cost", energy, 206);
        tick();
        chk("R4 busy off", busy, 1);
        tick();
        chk("R4 off busy end", busy, 0);
        chk("R4 off no charge", energy, 206);
        tick();
        chk("R6 strobes ignored", energy, 207);
    endtask

    // R3/R4 zero latency into idle; R5 idle base.
    task automatic t_to_idle();
        set_ev(0, 0, 0, 0);
        req_idle = 1;
        tick();
        req_idle = 0;
        chk("R3 idle move", energy, 257);
        chk("R4 zero latency", busy, 0);
        chk("R3 idle mode", mode, 1);
        tick();
        chk("R5 idle base", energy, 267);
        ev_add = 1;
        tick();
        ev_add = 0;
        chk("R5 idle add", energy, 280);
    endtask

    // R8 saturation, R9 clear from max.
    task automatic t_saturate();
        req_off = 1; tick(); req_off = 0;
        tick(); tick(); tick();
        for (int a = 0; a < 6; a++) wr_cfg(a, 255);
        req_idle = 1; tick(); req_idle = 0;
        set_ev(1, 1, 1, 1);
        for (int i = 0; i < 400; i++) begin
            bus_in = ~bus_in;
            tick();
        end
        chk("R8 saturated", energy, (1 << EW) - 1);
        bus_in = ~bus_in;
        tick();
        chk("R8 holds max", energy, (1 << EW) - 1);
        energy_clr = 1;
        tick();
        chk("R9 clear from max", energy, 0);
        energy_clr = 0;
        set_ev(0, 0, 0, 0);
    endtask

    initial begin
        tick();
        t_reset();
        t_off_leak();
        t_to_active();
        t_active_events();
        t_locked_and_same();
        t_to_off();
        t_to_idle();
        t_saturate();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule